// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is a bus master that sends bytes onto a two-wire serial bus under software control through three small registers. Software first checks that the bus is idle and sets the master and transmit mode bits. It then asks for a START condition and waits for the completion flag. After that it loads each byte (first the 7-bit target address with the direction bit, then the payload) and clears the flag to send it. After every byte it reads back the target's acknowledge. A final control write asks for a STOP condition.

Both bus lines are open-drain. The block only ever pulls a line low or lets it float, and it watches the resolved lines through separate inputs. The clock line toggles at a fixed rate derived from the system clock. The bus-busy status comes from the observed lines, not from the block's own requests.

Register map (`reg_addr`): 0 = control, 1 = status, 2 = data. Control bits: [0] master, [1] transmit, [2] bus-busy (write: request, read: observed status), [3] start/stop select, [4] completion flag (write 0 clears, write 1 has no effect). Status bit [0] is the acknowledge bit.

Top module: `i2c_master_tx`

## Requirements
- R1: After reset both lines are released (`scl_oe`=0, `sda_oe`=0), the control register reads 0 (mode bits, select, flag and bus-busy all 0) and the status register reads 0.
- R2: A control write stores bits [0], [1] and [3], and they read back at those positions.
- R3: A control write with bit2=1, bit3=0, bit0=1 and bit1=1, issued while bus-busy reads 0 and the block is idle, pulls SDA low while SCL is high and then pulls SCL low. From then on control bit2 reads 1.
- R4: The completion flag (control bit4) becomes 1 when the START condition has finished and again at the end of every byte, with SCL then held low. It stays 1 until software clears it.
- R5: Writing the data register while the flag is 1 only stores the byte: no SCL pulse occurs until the flag is cleared. The byte is sent once the flag reads 0 and a byte is pending.
- R6: A byte goes out MSB first on eight SCL high pulses, with SDA changing only while SCL is low.
- R7: On a ninth SCL pulse the block releases SDA and samples it into status bit0. 0 means the byte was acknowledged and 1 means it was not.
- R8: A control write with bit2=0 and bit3=0 while holding the bus pulls SDA low with SCL low, releases SCL and then releases SDA while SCL is high. Afterwards both lines are released and control bit2 reads 0.
- R9: Each SCL high and low phase of a byte lasts exactly `CLK_DIV` system clock cycles.
- R10: A control write with bit3=1 requests neither START nor STOP, whatever bit2 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with `CLK_DIV`=4 and the default two-stage input synchroniser. This keeps a byte slot below a hundred cycles, so one bus transaction can carry all 256 byte values. The bench's target model acknowledges every byte except those whose low three bits are all ones. That sweep therefore exercises MSB-first shifting, both acknowledge outcomes and the load-only behaviour of the data register for every value. The same small divider lets the bench measure the SCL phase length exactly, and it checks that ignored select writes leave the lines idle.

// File: rtl/i2cm_pkg.sv
// Shared definitions for the serial-bus master transmitter.
// Assumes an 8-bit register interface with a 2-bit register select.
package i2cm_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] RA_STAT = 2'd1;
    localparam logic [REG_AW-1:0] RA_DATA = 2'd2;

    localparam int CB_MST  = 0;
    localparam int CB_TRS  = 1;
    localparam int CB_BUSY = 2;
    localparam int CB_SEL  = 3;
    localparam int CB_FLAG = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START_A,
        S_START_B,
        S_HOLD,
        S_BIT_SET,
        S_BIT_LO,
        S_BIT_HI,
        S_STOP_A,
        S_STOP_B,
        S_STOP_C
    } eng_state_t;
endpackage

// File: rtl/i2cm_divider.sv
// Half-period tick generator for the serial clock.
// Counts while enabled and pulses tick every HALF cycles.
// Restarts from zero whenever it is disabled. Assumes HALF >= 2.
module i2cm_divider #(
    parameter int HALF = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    // Count system cycles within one half period of SCL.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cm_busmon.sv
// Bus monitor: synchronises the sampled lines and tracks bus occupancy.
// Bus-busy sets on a START pattern (SDA falls while SCL high).
// It clears on a STOP pattern (SDA rises while SCL high).
// Assumes STAGES >= 2.
module i2cm_busmon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic busy
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              sda_prev;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    // Resynchronise both lines; reset value is the released level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
            sda_prev <= sda_s;
        end
    end

    // Track bus occupancy from observed START and STOP patterns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (scl_s && sda_prev && !sda_s) begin
            busy <= 1'b1;
        end else if (scl_s && !sda_prev && sda_s) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
// Line sequencer: produces START, byte shifting with acknowledge
// capture, and STOP on the open-drain outputs.
// Holds SCL low between steps and pulses done after START and after each byte.
// Assumes tick comes from a divider enabled by div_en.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int BITS = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             go,
    input  logic [BITS-1:0]  tx_byte,
    input  logic             tick,
    input  logic             sda_s,
    output logic             div_en,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             done,
    output logic             ack,
    output eng_state_t       state
);
    localparam int BCW = $clog2(BITS + 1);
    localparam logic [BCW-1:0] ACK_SLOT = BCW'(BITS);

    logic [BITS-1:0] shreg;
    logic [BCW-1:0]  bitcnt;

    assign div_en = (state != S_IDLE) && (state != S_HOLD);

    // Step through the bus phases and drive the open-drain enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            shreg  <= '0;
            bitcnt <= '0;
            ack    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start_req) begin
                        sda_oe <= 1'b1;
                        state  <= S_START_A;
                    end
                end
                S_START_A: begin
                    if (tick) begin
                        scl_oe <= 1'b1;
                        state  <= S_START_B;
                    end
                end
                S_START_B: begin
                    if (tick) begin
                        done  <= 1'b1;
                        state <= S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (stop_req) begin
                        sda_oe <= 1'b1;
                        state  <= S_STOP_A;
                    end else if (go) begin
                        shreg  <= tx_byte;
                        bitcnt <= '0;
                        state  <= S_BIT_SET;
                    end
                end
                S_BIT_SET: begin
                    sda_oe <= (bitcnt == ACK_SLOT) ? 1'b0 : ~shreg[BITS-1];
                    state  <= S_BIT_LO;
                end
                S_BIT_LO: begin
                    if (tick) begin
                        scl_oe <= 1'b0;
                        state  <= S_BIT_HI;
                    end
                end
                S_BIT_HI: begin
                    if (tick) begin
                        scl_oe <= 1'b1;
                        if (bitcnt == ACK_SLOT) begin
                            ack   <= sda_s;
                            done  <= 1'b1;
                            state <= S_HOLD;
                        end else begin
                            shreg  <= shreg << 1;
                            bitcnt <= bitcnt + 1'b1;
                            state  <= S_BIT_SET;
                        end
                    end
                end
                S_STOP_A: begin
                    if (tick) begin
                        scl_oe <= 1'b0;
                        state  <= S_STOP_B;
                    end
                end
                S_STOP_B: begin
                    if (tick) begin
                        sda_oe <= 1'b0;
                        state  <= S_STOP_C;
                    end
                end
                S_STOP_C: begin
                    if (tick) begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_master_tx.sv
// Top of the serial-bus master transmitter: register file, completion
// flag and the glue between software requests and the line sequencer.
// Assumes single-cycle write strobes and combinational register reads.
module i2c_master_tx
    import i2cm_pkg::*;
#(
    parameter int CLK_DIV     = 125,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);
    logic              mst_q, trs_q, sel_q, irq_q, pend_q;
    logic [BYTE_W-1:0] data_q;
    logic              wr_ctrl, wr_data;
    logic              start_req, stop_req, go;
    logic              tick, div_en, eng_done, ack_q;
    logic              scl_s, sda_s, bus_busy;
    eng_state_t        eng_state;

    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign wr_data = reg_we && (reg_addr == RA_DATA);

    assign start_req = wr_ctrl && reg_wdata[CB_BUSY] && !reg_wdata[CB_SEL]
                       && reg_wdata[CB_MST] && reg_wdata[CB_TRS] && !bus_busy;
    assign stop_req  = wr_ctrl && !reg_wdata[CB_BUSY] && !reg_wdata[CB_SEL];
    assign go        = (eng_state == S_HOLD) && pend_q && !irq_q;

    // Hold mode bits, the completion flag and the pending byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_q  <= 1'b0;
            trs_q  <= 1'b0;
            sel_q  <= 1'b0;
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_ctrl) begin
                mst_q <= reg_wdata[CB_MST];
                trs_q <= reg_wdata[CB_TRS];
                sel_q <= reg_wdata[CB_SEL];
            end
            if (eng_done) begin
                irq_q <= 1'b1;
            end else if (wr_ctrl && !reg_wdata[CB_FLAG]) begin
                irq_q <= 1'b0;
            end
            if (wr_data) begin
                data_q <= reg_wdata;
                pend_q <= 1'b1;
            end else if (go) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Return the selected register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_MST]  = mst_q;
                reg_rdata[CB_TRS]  = trs_q;
                reg_rdata[CB_BUSY] = bus_busy;
                reg_rdata[CB_SEL]  = sel_q;
                reg_rdata[CB_FLAG] = irq_q;
            end
            RA_STAT: reg_rdata[0] = ack_q;
            RA_DATA: reg_rdata = data_q;
            default: reg_rdata = '0;
        endcase
    end

    i2cm_divider #(.HALF(CLK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .tick  (tick)
    );

    i2cm_busmon #(.STAGES(SYNC_STAGES)) u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .busy  (bus_busy)
    );

    i2cm_engine #(.BITS(BYTE_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .go        (go),
        .tx_byte   (data_q),
        .tick      (tick),
        .sda_s     (sda_s),
        .div_en    (div_en),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .done      (eng_done),
        .ack       (ack_q),
        .state     (eng_state)
    );

    logic scl_unused;
    assign scl_unused = scl_s;
endmodule

// File: rtl/i2cm_checker.sv
// Temporal checks on the transmitter, bound into its top module.
// Assumes it sees the open-drain enables, flag, bus-busy and sequencer state.
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       irq,
    input eng_state_t state
);
    // SDA may change under a released SCL only for START or STOP.
    assert_sda_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
        |-> (state == S_START_A || state == S_STOP_C));

    // The flag rises only while SCL is held low.
    assert_flag_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> scl_oe);

    // Bus-busy drops only with both lines released.
    assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!scl_oe && !sda_oe));

    // While waiting for software, SCL stays pulled low.
    assert_hold_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> scl_oe);
endmodule

bind i2c_master_tx i2cm_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (bus_busy),
    .irq    (irq_q),
    .state  (eng_state)
);

// File: tb/test_i2c_master_tx.sv
// Bench: one transaction carrying all 256 byte values through a target model.
module test_i2c_master_tx;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe;
    logic       slv_ack = 1'b0;
    logic       scl_line, sda_line;

    int nchk = 0;
    int nerr = 0;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_ack);

    always #10 clk = ~clk;

    i2c_master_tx #(.CLK_DIV(DIV), .SYNC_STAGES(2)) i_i2c_master_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    // Target model: counts bus conditions, shifts in bits, answers the ninth pulse.
    int         start_cnt = 0;
    int         stop_cnt = 0;
    int         bitn = 0;
    int         pulses = 0;
    logic [7:0] rx_sh = '0;
    logic [7:0] rx_byte = '0;

    always @(negedge sda_line) if (rst_n && scl_line === 1'b1) begin
        start_cnt++;
        bitn = 0;
    end
    always @(posedge sda_line) if (rst_n && scl_line === 1'b1) stop_cnt++;
    always @(posedge scl_line) if (rst_n) begin
        pulses++;
        if (bitn < 8) begin
            rx_sh = {rx_sh[6:0], sda_line};
            bitn++;
        end else if (bitn == 8) begin
            rx_byte = rx_sh;
            bitn = 9;
        end
    end
    always @(negedge scl_line) if (rst_n) begin
        if (bitn == 8) slv_ack = (rx_sh[2:0] != 3'b111);
        else if (bitn == 9) begin
            slv_ack = 1'b0;
            bitn = 0;
        end
    end

    // Measure the length of each SCL high phase in system cycles.
    int hcnt = 0;
    int last_hi = 0;
    always @(negedge clk) begin
        if (scl_line === 1'b1) hcnt++;
        else if (hcnt != 0) begin
            last_hi = hcnt;
            hcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_ctrl(input int bitpos, input logic val, output bit ok);
        logic [7:0] v;
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd0, v);
            if (v[bitpos] == val) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit ok;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R1 stat", v, 0);
        chk(scl_oe == 1'b0, "R1 scl_oe", scl_oe, 0);
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);

        // R2: mode bits read back
        wr(2'd0, 8'h03);
        rd(2'd0, v); chk(v == 8'h03, "R2 mode", v, 3);

        // R10: select bit set means no START
        wr(2'd0, 8'h0F);
        repeat (10 * DIV) @(negedge clk);
        chk(start_cnt == 0, "R10 no start", start_cnt, 0);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R10 lines idle", {scl_oe, sda_oe}, 0);
        rd(2'd0, v); chk(v == 8'h0B, "R10 ctrl", v, 8'h0B);

        // R3/R4: START and completion flag
        wr(2'd0, 8'h07);
        wait_ctrl(4, 1'b1, ok);
        chk(ok, "R4 start flag", ok, 1);
        chk(start_cnt == 1, "R3 start seen", start_cnt, 1);
        rd(2'd0, v); chk(v[2] == 1'b1, "R3 busy", v[2], 1);
        chk(scl_oe == 1'b1, "R4 scl held", scl_oe, 1);

        for (int b = 0; b < 256; b++) begin
            wr(2'd2, 8'(b));
            p0 = pulses;
            repeat (3 * DIV) @(negedge clk);
            chk(pulses == p0 && scl_oe == 1'b1, "R5 load only", pulses - p0, 0);
            wr(2'd0, 8'h07);
            wait_ctrl(4, 1'b1, ok);
            chk(ok, "R4 byte flag", ok, 1);
            chk(rx_byte == 8'(b), "R6 byte", rx_byte, b);
            rd(2'd1, v);
            chk(v[0] == ((b % 8) == 7), "R7 ack", v[0], int'((b % 8) == 7));
            chk(scl_oe == 1'b1, "R4 scl held", scl_oe, 1);
            if (b == 0) chk(last_hi == DIV, "R9 high phase", last_hi, DIV);
        end

        // R8: STOP
        wr(2'd0, 8'h03);
        wait_ctrl(2, 1'b0, ok);
        chk(ok, "R8 busy clears", ok, 1);
        repeat (2 * DIV) @(negedge clk);
        chk(stop_cnt == 1, "R8 stop seen", stop_cnt, 1);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R8 lines released", {scl_oe, sda_oe}, 0);

        summary();
        $finish;
    end
endmodule